// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 36-bit words with a depth of 256, 512 or 1024 entries. It has a write port and a read port, each on its own free-running clock. The two clocks may be unrelated or may be the same clock. Each pointer crosses to the other clock through a Gray-coded two-stage synchronizer. Every flag is computed in the clock of the port that consumes it, so each port sees its own flags without any further synchronization.

There are two read timing modes. In the standard mode, the read port shows an empty flag and the write port shows a full flag, and a word leaves the buffer only when it is requested. In the look-ahead mode, the oldest word is placed on the read bus without any request. The read flag then means "output ready" and the write flag means "input ready". Two level flags report when the buffer is almost empty and when it is almost full. Each level flag has its own threshold. Both thresholds are set from one of three built-in values, or they are loaded after reset: either through the write data bus or bit by bit over a two-wire serial input.

A full reset empties the buffer and captures the timing mode and the threshold source from the pins. A partial reset empties the buffer but keeps the mode and both thresholds.

Top module: `fifo_flags_top`

## Requirements
- R1: Words leave in the order they were written, with all 36 bits intact. In standard mode, a read request while the read flag is 0 places the next word on `rdData` at the same `rdClk` edge that samples the request. `rdData` is 0 after either reset.
- R2: In standard mode, `rdFlag`=1 means no word is stored and `wrFlag`=1 means DEPTH words are stored. A write while full is ignored and is never read out. A read while empty leaves `rdData` unchanged.
- R3: In look-ahead mode (`fwftSel`=1 at full reset), the first word written into an empty buffer appears on `rdData` with `rdFlag`=1 and no read request. A read request consumes it. `wrFlag`=1 means there is room. The buffer then holds DEPTH+1 words, the output stage included.
- R4: `aeFlag`=1 when the number of readable words is at or below the empty threshold. In look-ahead mode this count includes the word held in the output stage.
- R5: `afFlag`=1 when DEPTH minus the number of stored words is at or below the full threshold.
- R6: `offSel` values 0, 1 and 2 set both thresholds to 8, 16 and 64. The value captured is the one on the pin at the last `wrClk` edge while `rstN` is low.
- R7: When `offSel`=3 and `serSel`=0, the first write after a full reset loads the empty threshold from `wrData[AW-1:0]` and the second write loads the full threshold. Neither of these words is stored as data.
- R8: When `offSel`=3 and `serSel`=1, 2*AW bits are shifted in from `serData` on `wrClk` edges where `serEn`=1. The empty threshold comes first, then the full threshold, each most significant bit first. Until the last bit arrives, the write flag reports no room and writes are ignored.
- R9: A partial reset (`partRstN`=0) empties the buffer and keeps the timing mode and both thresholds, whatever the selection pins show.
- R10: The timing mode is taken from `fwftSel` only during a full reset. Later changes of the pin have no effect.
- R11: Writes and reads that run at the same time on unrelated clocks lose no word and duplicate no word. The write pointer's Gray code changes by at most one bit per `wrClk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Full reset, active low, synchronous to both clocks |
| partRstN | input | 1 | Partial reset, active low, keeps the configuration |
| fwftSel | input | 1 | Timing mode captured at full reset (1 = look-ahead) |
| offSel | input | 2 | Threshold source captured at full reset (0/1/2 = 8/16/64, 3 = load) |
| serSel | input | 1 | With offSel=3: 1 = serial load, 0 = load over the data bus |
| serEn | input | 1 | Serial threshold shift enable |
| serData | input | 1 | Serial threshold bit |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Write data |
| wrFlag | output | 1 | Full (standard mode) or input ready (look-ahead mode) |
| afFlag | output | 1 | Almost full |
| rdEn | input | 1 | Read request |
| rdData | output | WIDTH | Read data |
| rdFlag | output | 1 | Empty (standard mode) or output ready (look-ahead mode) |
| aeFlag | output | 1 | Almost empty |

## Verification
The bench targets the exact boundaries of both level flags: one word on either side of each threshold, for all three built-in values and for both load methods. A comparison that is off by one, or that uses the wrong sense, flips the flag one word early or one word late. A write into a full buffer and a read from an empty one are followed by a complete drain. A design that accepts either access would show a duplicated or an extra word, or a flag that never settles. The bench changes the selection pins before a partial reset and shows that the mode and the thresholds survive it; a design that captured them again would flip the flag polarity or move the thresholds. A concurrent stream on unrelated clocks checks every word. Faulty pointer crossing would show up there as lost or repeated data.

// File: rtl/fifo_flags_pkg.sv
package fifo_flags_pkg;

  // Threshold source encoding on the offSel pins
  typedef enum logic [1:0] {
    OFS_EIGHT     = 2'd0,
    OFS_SIXTEEN   = 2'd1,
    OFS_SIXTYFOUR = 2'd2,
    OFS_LOAD      = 2'd3
  } ofsSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWr;
    logic outLoad;
    logic outClear;
  } dpStrobe_t;

  function automatic int unsigned dfltOffset(logic [1:0] sel);
    case (sel)
      OFS_EIGHT:     return 8;
      OFS_SIXTEEN:   return 16;
      OFS_SIXTYFOUR: return 64;
      default:       return 8;
    endcase
  endfunction

endpackage

// File: rtl/fifo_flags_dpath.sv
module fifo_flags_dpath
  import fifo_flags_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  dpStrobe_t        strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.memWr) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (strb.outClear)     rdData <= '0;
    else if (strb.outLoad) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/fifo_flags_ctrl.sv
module fifo_flags_ctrl
  import fifo_flags_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          partRstN,
  input  logic          fwftSel,
  input  logic [1:0]    offSel,
  input  logic          serSel,
  input  logic          serEn,
  input  logic          serData,
  input  logic          wrEn,
  input  logic [AW-1:0] progData,
  input  logic          rdEn,
  output dpStrobe_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrFlag,
  output logic          afFlag,
  output logic          rdFlag,
  output logic          aeFlag
);

  localparam int PW = AW + 1;
  localparam int SW = 2 * AW;
  localparam int CW = $clog2(SW + 1);
  localparam logic [PW-1:0] FULL_COUNT = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic          wrRstOk;
  logic          fwftW, loadSerW, progDone;
  logic [CW-1:0] progCnt;
  logic [AW-1:0] aeOff, afOff;
  logic [PW-1:0] wrBin, wrBinNext, wrGray, rdGrayS1, rdGrayS2;
  logic [PW-1:0] rdBinAtW, wrCount, wrFree;
  logic          memFull, noRoom, wrAccept;
  logic [PW-1:0] rdGray;

  assign wrRstOk = rstN && partRstN;

  // Configuration: captured in full reset, kept through partial reset
  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      fwftW    <= fwftSel;
      loadSerW <= serSel;
      progDone <= (offSel != OFS_LOAD);
      progCnt  <= '0;
      aeOff    <= AW'(dfltOffset(offSel));
      afOff    <= AW'(dfltOffset(offSel));
    end else if (!progDone) begin
      if (loadSerW) begin
        if (serEn) begin
          {aeOff, afOff} <= {aeOff[AW-2:0], afOff, serData};
          progCnt        <= progCnt + 1'b1;
          if (progCnt == CW'(SW - 1)) progDone <= 1'b1;
        end
      end else if (wrEn) begin
        if (progCnt == '0) begin
          aeOff   <= progData;
          progCnt <= CW'(1);
        end else begin
          afOff    <= progData;
          progDone <= 1'b1;
        end
      end
    end
  end

  assign rdBinAtW  = fromGray(rdGrayS2);
  assign wrCount   = wrBin - rdBinAtW;
  assign wrFree    = FULL_COUNT - wrCount;
  assign memFull   = (wrCount == FULL_COUNT);
  assign noRoom    = memFull || (!progDone && loadSerW);
  assign wrAccept  = wrEn && progDone && !memFull;
  assign wrBinNext = wrBin + 1'b1;

  always_ff @(posedge wrClk) begin
    if (!wrRstOk) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (wrAccept) begin
        wrBin  <= wrBinNext;
        wrGray <= toGray(wrBinNext);
      end
    end
  end

  assign wrFlag = fwftW ? !noRoom : noRoom;
  assign afFlag = (wrFree <= {1'b0, afOff});
  assign wrAddr = wrBin[AW-1:0];

  // ---------------- read domain ----------------
  logic          rdRstOk, fwftR, outValid;
  logic [PW-1:0] rdBin, wrGrayS1, wrGrayS2, wrBinAtR, memLevel, readLevel;
  logic          memEmpty, fetch, rdAdvance;

  assign rdRstOk = rstN && partRstN;

  always_ff @(posedge rdClk) begin
    if (!rstN) fwftR <= fwftSel;
  end

  assign wrBinAtR  = fromGray(wrGrayS2);
  assign memLevel  = wrBinAtR - rdBin;
  assign memEmpty  = (memLevel == '0);
  assign fetch     = !memEmpty && (!outValid || rdEn);
  assign rdAdvance = fwftR ? fetch : (rdEn && !memEmpty);

  always_ff @(posedge rdClk) begin
    if (!rdRstOk) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
      outValid <= 1'b0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (rdAdvance) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= toGray(rdBin + 1'b1);
      end
      if (fwftR) begin
        if (fetch)     outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end
    end
  end

  assign readLevel = memLevel + {{AW{1'b0}}, outValid};
  assign aeFlag    = (readLevel <= {1'b0, aeOff});
  assign rdFlag    = fwftR ? outValid : memEmpty;
  assign rdAddr    = rdBin[AW-1:0];

  assign strb = '{memWr: wrAccept, outLoad: rdAdvance, outClear: !rdRstOk};

  // ---------------- assertions ----------------
  assert_no_overflow_R2: assert property (@(posedge wrClk) disable iff (!wrRstOk)
    wrCount <= FULL_COUNT);

  assert_gray_step_R11: assert property (@(posedge wrClk) disable iff (!wrRstOk)
    $past(wrRstOk) |-> ($countones(wrGray ^ $past(wrGray)) <= 1));

  assert_offsets_kept_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    (!partRstN && progDone) |=> ($stable(aeOff) && $stable(afOff)));

  assert_no_underflow_R2: assert property (@(posedge rdClk) disable iff (!rdRstOk)
    memLevel <= FULL_COUNT);

  assert_empty_hold_R2: assert property (@(posedge rdClk) disable iff (!rdRstOk)
    (!fwftR && memEmpty) |=> $stable(rdBin));

  assert_fwft_fill_R3: assert property (@(posedge rdClk) disable iff (!rdRstOk)
    (fwftR && !outValid && !memEmpty) |=> outValid);

endmodule

// File: rtl/fifo_flags_top.sv
module fifo_flags_top
  import fifo_flags_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             partRstN,
  input  logic             fwftSel,
  input  logic [1:0]       offSel,
  input  logic             serSel,
  input  logic             serEn,
  input  logic             serData,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             wrFlag,
  output logic             afFlag,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdFlag,
  output logic             aeFlag
);

  localparam int AW = $clog2(DEPTH);

  dpStrobe_t     strb;
  logic [AW-1:0] wrAddr, rdAddr;

  fifo_flags_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .partRstN(partRstN),
    .fwftSel(fwftSel), .offSel(offSel), .serSel(serSel),
    .serEn(serEn), .serData(serData), .wrEn(wrEn),
    .progData(wrData[AW-1:0]), .rdEn(rdEn), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrFlag(wrFlag), .afFlag(afFlag),
    .rdFlag(rdFlag), .aeFlag(aeFlag)
  );

  fifo_flags_dpath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/fifo_flags_top_tb.sv
module fifo_flags_top_tb;

  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic rstN = 1'b0, partRstN = 1'b1, fwftSel = 1'b0, serSel = 1'b0;
  logic [1:0] offSel = 2'd1;
  logic serEn = 1'b0, serData = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [35:0] wrData = '0;
  logic [35:0] rdData;
  logic wrFlag, afFlag, rdFlag, aeFlag;
  int nChecks = 0, nFail = 0;

  always #10 wrClk = ~wrClk;  // 50 MHz write clock
  always #13 rdClk = ~rdClk;  // unrelated read clock

  fifo_flags_top u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .partRstN(partRstN),
    .fwftSel(fwftSel), .offSel(offSel), .serSel(serSel), .serEn(serEn),
    .serData(serData), .wrEn(wrEn), .wrData(wrData), .wrFlag(wrFlag),
    .afFlag(afFlag), .rdEn(rdEn), .rdData(rdData), .rdFlag(rdFlag),
    .aeFlag(aeFlag)
  );

  function automatic logic [35:0] pat(int i);
    return {4'(i * 7 + 3), 32'hC0DE0000 + 32'(i)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge wrClk);
    repeat (6) @(posedge rdClk);
    @(negedge rdClk);
  endtask

  task automatic doReset(logic fw, logic [1:0] sel, logic ser);
    @(negedge wrClk);
    fwftSel = fw; offSel = sel; serSel = ser; rstN = 1'b0;
    repeat (4) @(posedge wrClk);
    repeat (4) @(posedge rdClk);
    @(negedge wrClk) rstN = 1'b1;
    settle();
  endtask

  task automatic partReset(logic fwPin, logic [1:0] selPin);
    @(negedge wrClk);
    fwftSel = fwPin; offSel = selPin; partRstN = 1'b0;
    repeat (4) @(posedge wrClk);
    repeat (4) @(posedge rdClk);
    @(negedge wrClk) partRstN = 1'b1;
    settle();
  endtask

  task automatic push(logic [35:0] d);
    @(negedge wrClk); wrEn = 1'b1; wrData = d;
    @(negedge wrClk); wrEn = 1'b0;
  endtask

  task automatic pop(output logic [35:0] d);
    @(negedge rdClk) rdEn = 1'b1;
    @(negedge rdClk) rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic t_reset_state();
    doReset(1'b0, 2'd1, 1'b0);
    chk("R2 empty after reset", rdFlag, 1);
    chk("R2 not full after reset", wrFlag, 0);
    chk("R4 ae after reset", aeFlag, 1);
    chk("R5 af after reset", afFlag, 0);
    chk("R1 rdData zero after reset", rdData, 0);
  endtask

  task automatic t_fill_drain();
    logic [35:0] d;
    doReset(1'b0, 2'd1, 1'b0);
    for (int i = 0; i < 16; i++) push(pat(i));
    settle(); chk("R4 ae at 16 (R6 default 16)", aeFlag, 1);
    chk("R2 not empty", rdFlag, 0);
    push(pat(16));
    settle(); chk("R4 ae at 17", aeFlag, 0);
    for (int i = 17; i < 239; i++) push(pat(i));
    settle(); chk("R5 af at 239", afFlag, 0);
    push(pat(239));
    settle(); chk("R5 af at 240", afFlag, 1);
    chk("R2 not full at 240", wrFlag, 0);
    for (int i = 240; i < 256; i++) push(pat(i));
    settle(); chk("R2 full at DEPTH", wrFlag, 1);
    push(36'hF_FFFF_FFFF);
    settle();
    for (int i = 0; i < 256; i++) begin
      pop(d);
      chk("R1 drain order", d, pat(i));
    end
    settle();
    chk("R2 empty after drain (no extra word)", rdFlag, 1);
    chk("R2 not full after drain", wrFlag, 0);
    pop(d);
    chk("R2 read when empty leaves data", d, pat(255));
  endtask

  task automatic t_defaults();
    doReset(1'b0, 2'd0, 1'b0);
    for (int i = 0; i < 8; i++) push(pat(i));
    settle(); chk("R6 ae at 8 with default 8", aeFlag, 1);
    push(pat(8));
    settle(); chk("R6 ae at 9 with default 8", aeFlag, 0);
    doReset(1'b0, 2'd2, 1'b0);
    for (int i = 0; i < 64; i++) push(pat(i));
    settle(); chk("R6 ae at 64 with default 64", aeFlag, 1);
    push(pat(64));
    settle(); chk("R6 ae at 65 with default 64", aeFlag, 0);
  endtask

  task automatic t_fwft();
    logic [35:0] d;
    doReset(1'b1, 2'd0, 1'b0);
    chk("R3 not ready after reset", rdFlag, 0);
    chk("R3 input ready after reset", wrFlag, 1);
    push(pat(1000));
    settle();
    chk("R3 word shown without read", rdFlag, 1);
    chk("R3 first word on bus", rdData, pat(1000));
    chk("R4 ae counts output stage", aeFlag, 1);
    push(pat(1001));
    settle();
    pop(d);
    chk("R3 read consumes and shows next", d, pat(1001));
    chk("R3 still ready", rdFlag, 1);
    pop(d);
    chk("R3 not ready once drained", rdFlag, 0);
    for (int i = 0; i < 256; i++) push(pat(i));
    settle(); chk("R3 room with DEPTH words", wrFlag, 1);
    push(pat(256));
    settle(); chk("R3 no room at DEPTH+1", wrFlag, 0);
  endtask

  task automatic t_partial_fwft();
    partReset(1'b0, 2'd2);
    chk("R9 emptied, R10 mode kept (ready=0)", rdFlag, 0);
    chk("R10 mode kept (input ready=1)", wrFlag, 1);
    for (int i = 0; i < 8; i++) push(pat(300 + i));
    settle();
    chk("R9 threshold 8 kept", aeFlag, 1);
    chk("R10 word shown without read", rdData, pat(300));
    push(pat(308));
    settle(); chk("R9 threshold 8 kept, 9 words", aeFlag, 0);
  endtask

  task automatic t_parallel();
    logic [35:0] d;
    doReset(1'b0, 2'd3, 1'b0);
    chk("R7 room while loading", wrFlag, 0);
    push(36'd5);
    push(36'd250);
    for (int i = 0; i < 5; i++) push(pat(i));
    settle();
    chk("R7 ae at 5 with loaded 5", aeFlag, 1);
    chk("R7 af at 5 with loaded 250", afFlag, 0);
    push(pat(5));
    settle();
    chk("R7 ae at 6", aeFlag, 0);
    chk("R7 af at 6", afFlag, 1);
    pop(d);
    chk("R7 load words not stored", d, pat(0));
    partReset(1'b1, 2'd0);
    chk("R9 empty after partial reset, R10 mode kept", rdFlag, 1);
    for (int i = 0; i < 5; i++) push(pat(i));
    settle();
    chk("R9 ae threshold kept", aeFlag, 1);
    chk("R9 af threshold kept", afFlag, 0);
    push(pat(5));
    settle();
    chk("R9 ae threshold kept at 6", aeFlag, 0);
    chk("R9 af threshold kept at 6", afFlag, 1);
  endtask

  task automatic t_serial();
    logic [35:0] d;
    logic [2*AW-1:0] bits;
    bits = {8'd3, 8'd10};
    doReset(1'b0, 2'd3, 1'b1);
    chk("R8 no room before load", wrFlag, 1);
    push(pat(77));
    for (int i = 2 * AW - 1; i >= 0; i--) begin
      @(negedge wrClk); serEn = 1'b1; serData = bits[i];
    end
    @(negedge wrClk); serEn = 1'b0;
    settle();
    chk("R8 room after load", wrFlag, 0);
    chk("R8 ignored write not stored", rdFlag, 1);
    for (int i = 0; i < 3; i++) push(pat(i));
    settle(); chk("R8 ae at 3 with loaded 3", aeFlag, 1);
    push(pat(3));
    settle(); chk("R8 ae at 4", aeFlag, 0);
    pop(d);
    chk("R8 first word after load", d, pat(0));
    for (int i = 0; i < 242; i++) push(pat(10 + i));
    settle(); chk("R8 af at 245 with loaded 10", afFlag, 0);
    push(pat(252));
    settle(); chk("R8 af at 246", afFlag, 1);
  endtask

  task automatic t_concurrent();
    doReset(1'b0, 2'd0, 1'b0);
    fork
      begin
        for (int i = 0; i < 40; i++) push(pat(500 + i));
      end
      begin
        int got;
        bit pend;
        got = 0;
        pend = 1'b0;
        while (got < 40) begin
          @(negedge rdClk);
          if (pend) begin
            chk("R11 concurrent order", rdData, pat(500 + got));
            got++;
          end
          rdEn = !rdFlag && (got < 40);
          pend = rdEn;
        end
      end
    join
    settle();
    chk("R11 empty after stream", rdFlag, 1);
  endtask

  initial begin
    repeat (150000) @(posedge wrClk);
    nChecks++; nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_fill_drain();
    t_defaults();
    t_fwft();
    t_partial_fwft();
    t_parallel();
    t_serial();
    t_concurrent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule